// File: doc/BRIEF.md
# Snoop Intervention Response Combiner

This block sits on a shared system bus that several processor subsystems use, four in the default configuration. It gathers the results of the interventions that one coherent read triggers. When the read response phase opens, the combiner asks the agent of every subsystem other than the requester to query its processor for the target line. It keeps the response phase open until each of those agents has reported. It then reduces the reports to one outcome for the requester: a shared indication, a takeover flag with the index of the owning agent, and a protocol-error flag.

Each agent reports on a 2-bit code:

| Code | Meaning |
|------|---------|
| 00 | not ready |
| 01 | clean miss |
| 10 | sharing |
| 11 | takeover (the processor holds the line dirty exclusive) |

The combiner latches the first non-zero code from each agent. During a read-exclusive phase it raises an invalidate indication, so that responders drop their copies.

The controller has three states:

- `ST_IDLE` waits for a start. A start moves it to `ST_COLLECT` and latches the requester index and the exclusive bit.
- `ST_COLLECT` keeps the phase open. It moves to `ST_FINISH` at the edge where the last missing report is captured.
- `ST_FINISH` presents the result for one cycle and returns to `ST_IDLE`.

Top module: `snoop_resp_combiner`

## Requirements
- R1: After reset, `resp_busy`, `resp_done` and all `snoop_req` bits are 0.
- R2: A `rd_start` sampled while idle opens the phase. From the next cycle `resp_busy` is 1 and `snoop_req` has a 1 for every agent except `rd_req_id`. `snoop_inval` equals the latched `rd_excl` while busy.
- R3: `resp_busy` stays 1 while any non-requesting agent has not yet reported a non-zero code. An agent's `snoop_req` bit clears once its report has been captured.
- R4: `resp_done` is a one-cycle pulse in the cycle after the edge that captures the last missing report. `resp_busy` is 0 while `resp_done` is 1.
- R5: For an ordinary read (`rd_excl`=0), `resp_shared` is 1 exactly when some non-requesting agent reported 10.
- R6: For a read exclusive (`rd_excl`=1), `resp_shared` is 0 whatever the reports are.
- R7: `resp_takeover` is 1 when some non-requesting agent reported 11. `resp_owner` is then the lowest such agent index.
- R8: The requester's own code is never captured and has no effect on any result. It receives no `snoop_req`.
- R9: `resp_err` is 1, together with `resp_done`, when two or more non-requesting agents reported 11.
- R10: Only the first non-zero code of each agent counts. A later change during the same phase is ignored.
- R11: A `rd_start` that arrives while a phase is open is ignored. The current phase and its result are unchanged.
- R12: `resp_shared`, `resp_takeover`, `resp_owner` and `resp_err` are 0 whenever `resp_done` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_start | input | 1 | Opens the read response phase of a coherent read |
| rd_excl | input | 1 | 1 = read exclusive, 0 = ordinary read; sampled with `rd_start` |
| rd_req_id | input | IDW | Index of the requesting subsystem; sampled with `rd_start` |
| agt_code | input | 2*N_AGENTS | Per-agent report codes; agent i uses bits [2i+1:2i] |
| snoop_req | output | N_AGENTS | Intervention request per agent, held until that agent reports |
| snoop_inval | output | 1 | The current phase is for a read exclusive; responders invalidate |
| resp_busy | output | 1 | Response phase held open |
| resp_done | output | 1 | One-cycle strobe: the result is valid |
| resp_shared | output | 1 | Final shared indication |
| resp_takeover | output | 1 | Some agent takes over as the dirty owner |
| resp_owner | output | IDW | Index of the takeover agent |
| resp_err | output | 1 | More than one takeover was reported |

## Verification
The bench varies report arrival so that the last agent answers at once in some phases and several cycles late in others. A design that closes the phase early fails the busy check or returns a result built from a not-ready code. Some phases give the requester a sharing or takeover code of its own. A combiner that fails to mask the requester would then report a false outcome.

Other phases change an agent's code after its first report, or repeat the start pulse mid-phase. A design without sticky capture or without start gating would flip the shared result or restart collection and produce a second done pulse. A double-takeover case checks the error flag. A sharing-only read exclusive checks that the shared indication is suppressed.

// File: rtl/snp_pkg.sv
package snp_pkg;

    // Agent report encoding
    typedef enum logic [1:0] {
        RPT_NONE  = 2'b00,
        RPT_MISS  = 2'b01,
        RPT_SHARE = 2'b10,
        RPT_TAKE  = 2'b11
    } rpt_e;

    // Response phase controller states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_COLLECT = 2'b01,
        ST_FINISH  = 2'b10
    } st_e;

endpackage

// File: rtl/snp_slot.sv
module snp_slot
    import snp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic exclude_i,
    input  logic cap_i,
    input  rpt_e code_i,
    output logic got_o,
    output logic got_nx_o,
    output rpt_e code_o
);

    logic take_now;

    always_comb begin
        take_now = cap_i && !got_o && (code_i != RPT_NONE);
        got_nx_o = got_o || take_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            got_o  <= 1'b0;
            code_o <= RPT_NONE;
        end else if (clear_i) begin
            got_o  <= exclude_i;
            code_o <= RPT_NONE;
        end else if (take_now) begin
            got_o  <= 1'b1;
            code_o <= code_i;
        end
    end

    // R10
    sticky_rpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (got_o && !clear_i) |=> (got_o && $stable(code_o)));

endmodule

// File: rtl/snp_reduce.sv
module snp_reduce
    import snp_pkg::*;
#(
    parameter int N_AGENTS = 4,
    parameter int IDW      = 2
) (
    input  rpt_e [N_AGENTS-1:0] codes_i,
    input  logic [N_AGENTS-1:0] include_i,
    input  logic                excl_i,
    output logic                shared_o,
    output logic                take_o,
    output logic [IDW-1:0]      owner_o,
    output logic                multi_o
);

    logic [N_AGENTS-1:0] share_vec;
    logic [N_AGENTS-1:0] take_vec;

    always_comb begin
        for (int i = 0; i < N_AGENTS; i++) begin
            share_vec[i] = include_i[i] && (codes_i[i] == RPT_SHARE);
            take_vec[i]  = include_i[i] && (codes_i[i] == RPT_TAKE);
        end
        shared_o = !excl_i && (|share_vec);
        take_o   = |take_vec;
        multi_o  = ($countones(take_vec) > 1);
        owner_o  = '0;
        for (int i = N_AGENTS - 1; i >= 0; i--) begin
            if (take_vec[i]) owner_o = IDW'(i);
        end
    end

endmodule

// File: rtl/snp_fsm.sv
module snp_fsm
    import snp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic all_got_i,
    output logic clear_o,
    output logic cap_o,
    output logic busy_o,
    output logic done_o
);

    st_e state_q, state_nx;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i)   state_nx = ST_COLLECT;
            ST_COLLECT: if (all_got_i) state_nx = ST_FINISH;
            ST_FINISH:                 state_nx = ST_IDLE;
            default:                   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        clear_o = 1'b0;
        cap_o   = 1'b0;
        busy_o  = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:    clear_o = start_i;
            ST_COLLECT: begin
                cap_o  = 1'b1;
                busy_o = 1'b1;
            end
            ST_FINISH:  done_o = 1'b1;
            default:    ;
        endcase
    end

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R4
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_o));

    // R3
    hold_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !all_got_i) |=> busy_o);

endmodule

// File: rtl/snoop_resp_combiner.sv
module snoop_resp_combiner
    import snp_pkg::*;
#(
    parameter int N_AGENTS = 4,
    parameter int IDW      = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_start,
    input  logic                  rd_excl,
    input  logic [IDW-1:0]        rd_req_id,
    input  logic [2*N_AGENTS-1:0] agt_code,
    output logic [N_AGENTS-1:0]   snoop_req,
    output logic                  snoop_inval,
    output logic                  resp_busy,
    output logic                  resp_done,
    output logic                  resp_shared,
    output logic                  resp_takeover,
    output logic [IDW-1:0]        resp_owner,
    output logic                  resp_err
);

    logic                clear, cap;
    logic [IDW-1:0]      req_q;
    logic                excl_q;
    logic [N_AGENTS-1:0] req_new_oh, req_oh_q;
    logic [N_AGENTS-1:0] got, got_nx;
    rpt_e [N_AGENTS-1:0] codes;
    logic                red_shared, red_take, red_multi;
    logic [IDW-1:0]      red_owner;

    always_comb begin
        for (int i = 0; i < N_AGENTS; i++) begin
            req_new_oh[i] = (rd_req_id == IDW'(i));
            req_oh_q[i]   = (req_q == IDW'(i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q  <= '0;
            excl_q <= 1'b0;
        end else if (clear) begin
            req_q  <= rd_req_id;
            excl_q <= rd_excl;
        end
    end

    snp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (rd_start),
        .all_got_i (&got_nx),
        .clear_o   (clear),
        .cap_o     (cap),
        .busy_o    (resp_busy),
        .done_o    (resp_done)
    );

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_slot
        snp_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear_i   (clear),
            .exclude_i (req_new_oh[g]),
            .cap_i     (cap),
            .code_i    (rpt_e'(agt_code[2*g +: 2])),
            .got_o     (got[g]),
            .got_nx_o  (got_nx[g]),
            .code_o    (codes[g])
        );
    end

    snp_reduce #(
        .N_AGENTS (N_AGENTS),
        .IDW      (IDW)
    ) u_reduce (
        .codes_i   (codes),
        .include_i (~req_oh_q),
        .excl_i    (excl_q),
        .shared_o  (red_shared),
        .take_o    (red_take),
        .owner_o   (red_owner),
        .multi_o   (red_multi)
    );

    always_comb begin
        snoop_req     = {N_AGENTS{resp_busy}} & ~got;
        snoop_inval   = resp_busy && excl_q;
        resp_shared   = resp_done && red_shared;
        resp_takeover = resp_done && red_take;
        resp_owner    = resp_done ? red_owner : '0;
        resp_err      = resp_done && red_multi;
    end

    // R8
    no_self_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_busy |-> ((snoop_req & req_oh_q) == '0));

    // R6
    excl_noshare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_done && excl_q) |-> !resp_shared);

    // R9
    err_has_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> (resp_done && resp_takeover));

    // R12
    quiet_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_done |-> !(resp_shared || resp_takeover || resp_err));

endmodule

// File: tb/snoop_resp_combiner_tb.sv
module snoop_resp_combiner_tb;

    localparam int N   = 4;
    localparam int IDW = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           rd_start = 1'b0;
    logic           rd_excl = 1'b0;
    logic [IDW-1:0] rd_req_id = '0;
    logic [2*N-1:0] agt_code = '0;
    logic [N-1:0]   snoop_req;
    logic           snoop_inval, resp_busy, resp_done, resp_shared, resp_takeover, resp_err;
    logic [IDW-1:0] resp_owner;

    always #10 clk = ~clk;

    snoop_resp_combiner #(.N_AGENTS(N), .IDW(IDW)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_excl(rd_excl),
        .rd_req_id(rd_req_id), .agt_code(agt_code), .snoop_req(snoop_req),
        .snoop_inval(snoop_inval), .resp_busy(resp_busy), .resp_done(resp_done),
        .resp_shared(resp_shared), .resp_takeover(resp_takeover),
        .resp_owner(resp_owner), .resp_err(resp_err)
    );

    typedef struct packed {
        logic       shared;
        logic       take;
        logic [1:0] owner;
        logic       err;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops one expected result per done strobe
    logic done_prev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            // R4: single-cycle done
            if (resp_done && done_prev) chk(0, "R4", "done pulse width", 2, 1);
            if (resp_done) begin
                if (q.size() == 0) begin
                    chk(0, "R11", "unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(resp_shared == e.shared, "R5", "shared", int'(resp_shared), int'(e.shared));
                    chk(resp_takeover == e.take, "R7", "takeover", int'(resp_takeover), int'(e.take));
                    if (e.take) chk(resp_owner == e.owner, "R7", "owner", int'(resp_owner), int'(e.owner));
                    chk(resp_err == e.err, "R9", "error", int'(resp_err), int'(e.err));
                end
            end else begin
                // R12
                chk(!(resp_shared || resp_takeover || resp_err), "R12", "result while not done",
                    int'({resp_shared, resp_takeover, resp_err}), 0);
            end
        end
        done_prev <= resp_done;
    end

    task automatic run_read(input int rid, input bit ex, input logic [1:0] cd [4], input int dl [4],
                            input int late_ag, input logic [1:0] late_cd, input int late_at,
                            input bit restart);
        exp_t e;
        int   last;
        int   ntake;
        e = '0;
        last = 0;
        ntake = 0;
        for (int i = 0; i < N; i++) begin
            if (i != rid) begin
                if (dl[i] > last) last = dl[i];
                if (cd[i] == 2'b10 && !ex) e.shared = 1'b1;
                if (cd[i] == 2'b11) begin
                    if (!e.take) e.owner = 2'(i);
                    e.take = 1'b1;
                    ntake++;
                end
            end
        end
        e.err = (ntake > 1);
        q.push_back(e);

        @(negedge clk);
        rd_req_id = IDW'(rid);
        rd_excl   = ex;
        rd_start  = 1'b1;
        agt_code  = '0;
        @(negedge clk);
        rd_start = 1'b0;
        for (int c = 0; c <= last; c++) begin
            chk(resp_busy == 1'b1, "R3", "busy while reports missing", int'(resp_busy), 1);
            if (c == 0) begin
                logic [N-1:0] want;
                want = ~(N'(1) << rid);
                chk(snoop_req == want, "R2", "snoop_req at open", int'(snoop_req), int'(want));
                chk(snoop_inval == ex, "R6", "snoop_inval", int'(snoop_inval), int'(ex));
            end
            if (restart && c == 1) begin
                rd_start  = 1'b1;
                rd_req_id = IDW'((rid + 1) % N);
                rd_excl   = ~ex;
            end
            if (restart && c == 2) rd_start = 1'b0;
            for (int i = 0; i < N; i++)
                if (dl[i] == c) agt_code[2*i +: 2] = cd[i];
            if (late_ag >= 0 && c == late_at) agt_code[2*late_ag +: 2] = late_cd;
            @(negedge clk);
            // R3: an agent's request drops after its report is captured
            for (int i = 0; i < N; i++)
                if (i != rid && dl[i] <= c && c < last)
                    chk(snoop_req[i] == 1'b0, "R3", "snoop_req after report", int'(snoop_req[i]), 0);
        end
        chk(resp_done == 1'b1, "R4", "done timing", int'(resp_done), 1);
        chk(resp_busy == 1'b0, "R4", "busy during done", int'(resp_busy), 0);
        rd_start = 1'b0;
        @(negedge clk);
        chk(resp_done == 1'b0, "R4", "done falls", int'(resp_done), 0);
        agt_code = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(resp_busy == 0, "R1", "busy after reset", int'(resp_busy), 0);
        chk(resp_done == 0, "R1", "done after reset", int'(resp_done), 0);
        chk(snoop_req == 0, "R1", "snoop_req after reset", int'(snoop_req), 0);

        // R5 ordinary read with one sharer
        run_read(0, 0, '{2'd0, 2'd1, 2'd2, 2'd1}, '{0, 0, 2, 1}, -1, 2'd0, 0, 0);
        // R7 takeover by agent 0, late
        run_read(2, 0, '{2'd3, 2'd1, 2'd0, 2'd1}, '{3, 1, 0, 0}, -1, 2'd0, 0, 0);
        // R6 read exclusive with sharers and a takeover
        run_read(1, 1, '{2'd2, 2'd0, 2'd2, 2'd3}, '{0, 0, 1, 4}, -1, 2'd0, 0, 0);
        // R8 requester reports takeover and is ignored
        run_read(3, 0, '{2'd1, 2'd1, 2'd1, 2'd3}, '{1, 0, 2, 0}, -1, 2'd0, 0, 0);
        // R8 requester reports sharing and is ignored
        run_read(2, 0, '{2'd1, 2'd1, 2'd2, 2'd1}, '{0, 0, 0, 1}, -1, 2'd0, 0, 0);
        // R9 two takeovers
        run_read(0, 0, '{2'd1, 2'd3, 2'd1, 2'd3}, '{0, 0, 1, 2}, -1, 2'd0, 0, 0);
        // R10 agent 1 changes miss to sharing after reporting
        run_read(0, 0, '{2'd0, 2'd1, 2'd1, 2'd1}, '{0, 0, 1, 4}, 1, 2'd2, 2, 0);
        // R10 agent 2 changes miss to takeover after reporting
        run_read(3, 0, '{2'd1, 2'd1, 2'd1, 2'd0}, '{3, 1, 0, 0}, 2, 2'd3, 1, 0);
        // R11 start repeated mid-phase
        run_read(1, 0, '{2'd1, 2'd0, 2'd2, 2'd1}, '{1, 0, 2, 3}, -1, 2'd0, 0, 1);
        // R4 all agents report at once
        run_read(0, 1, '{2'd0, 2'd3, 2'd1, 2'd1}, '{0, 0, 0, 0}, -1, 2'd0, 0, 0);

        for (int k = 0; k < 24; k++) begin
            logic [1:0] cd [4];
            int         dl [4];
            int         rid;
            rid = int'($urandom_range(N - 1, 0));
            for (int i = 0; i < N; i++) begin
                cd[i] = 2'($urandom_range(3, 1));
                dl[i] = int'($urandom_range(5, 0));
            end
            run_read(rid, bit'($urandom_range(1, 0)), cd, dl, -1, 2'd0, 0, 0);
        end

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R4", "missing done strobes", q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R3 watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule